// File: doc/BRIEF.md
# Single-Cycle Load-Store Processor Core

This block is a 32-bit processor core that completes one instruction on every rising clock edge. Arithmetic operates only on the general registers. Memory is reached only through word loads and stores. A load or store forms its address from a base register plus a signed 16-bit displacement. The core supports register arithmetic (add, sub, slt), immediate arithmetic and logic (addi, slti, andi, ori, lui), word loads and stores, the two equality branches, absolute jumps, jump-and-link and register-indirect jumps.

The instruction port and the data port are byte-addressed and carry whole aligned words. The instruction word for the current PC is expected in the same cycle. Data-memory reads are also combinational, and stores commit at the clock edge that ends the instruction. The register file has 32 entries, and entry 0 is hard-wired to zero. An observation port shows the current PC and every register write as it retires, so a surrounding environment can follow execution without reaching into the core.

Top module: `lsr_core`

## Requirements
- R1: While reset is held the PC equals the parameter `RESET_PC` (default 0). Afterwards, each non-control-transfer instruction advances the PC by 4.
- R2: Opcode 0 with function code 32 writes rs+rt to rd. Function code 34 writes rs−rt to rd. The fields are op[31:26], rs[25:21], rt[20:16], rd[15:11] and funct[5:0].
- R3: Function code 42 (opcode 0) writes 1 to rd when rs < rt as signed values, and 0 otherwise. Opcode 10 makes the same signed test of rs against the sign-extended imm[15:0] and writes the result to rt.
- R4: Opcode 8 writes rs + sign-extended immediate to rt. Opcodes 12 and 13 AND or OR rs with the zero-extended immediate. Opcode 15 writes {imm, 16'h0} to rt.
- R5: Opcode 35 loads the word at rs + sign-extended imm into rt. Opcode 43 drives that address with write enable and the value of rt, and writes no register.
- R6: Register 0 always reads zero. A write aimed at it is dropped and does not appear on the observation port.
- R7: Opcode 4 (equal) and opcode 5 (not equal) compare rs with rt. When taken, the next PC is PC+4 + (sign-extended imm << 2). Otherwise the next PC is PC+4.
- R8: Opcode 2 jumps to {PC+4[31:28], addr[25:0], 2'b00}. Opcode 3 jumps to the same target and writes PC+4 to register 31.
- R9: Function code 8 with opcode 0 loads the PC from rs and writes no register.
- R10: Any other opcode, or any other function code under opcode 0, writes no register and no memory, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 32 | Byte address of the instruction being fetched (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Byte address of the load or store (rs + offset) |
| dmem_rdata | input | 32 | Word at `dmem_addr`, same cycle |
| dmem_wdata | output | 32 | Store data (value of rt) |
| dmem_we | output | 1 | Store strobe; the word is written at the clock edge |
| dbg_pc | output | 32 | Current PC |
| dbg_wr_en | output | 1 | A register write retires this cycle |
| dbg_wr_idx | output | 5 | Index of the register written |
| dbg_wr_data | output | 32 | Value written |

## Verification
The bench builds the core with the default `RESET_PC` of 0. A short program placed at address 0 then reaches every opcode and function code in the subset. The program also exercises a taken equal-branch, a not-taken not-equal branch, a link through register 31 and an indirect jump. It performs a store and load with a negative displacement, a write aimed at register 0, and two undecodable words. With the reset address at 0, the absolute jump targets and the link value can be written down directly from the word positions. A scoreboard checks the ordered stream of register writes and stores, so a skipped instruction, a missing write or an extra write all show up as mismatches.

// File: rtl/lsr_core.sv
module lsr_core #(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  input  logic [31:0] dmem_rdata,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  output logic [31:0] dbg_pc,
  output logic        dbg_wr_en,
  output logic [4:0]  dbg_wr_idx,
  output logic [31:0] dbg_wr_data
);
  localparam logic [5:0] OP_REG  = 6'd0;
  localparam logic [5:0] OP_J    = 6'd2;
  localparam logic [5:0] OP_JAL  = 6'd3;
  localparam logic [5:0] OP_BEQ  = 6'd4;
  localparam logic [5:0] OP_BNE  = 6'd5;
  localparam logic [5:0] OP_ADDI = 6'd8;
  localparam logic [5:0] OP_SLTI = 6'd10;
  localparam logic [5:0] OP_ANDI = 6'd12;
  localparam logic [5:0] OP_ORI  = 6'd13;
  localparam logic [5:0] OP_LUI  = 6'd15;
  localparam logic [5:0] OP_LW   = 6'd35;
  localparam logic [5:0] OP_SW   = 6'd43;
  localparam logic [5:0] FN_JR   = 6'd8;
  localparam logic [5:0] FN_ADD  = 6'd32;
  localparam logic [5:0] FN_SUB  = 6'd34;
  localparam logic [5:0] FN_SLT  = 6'd42;
  localparam logic [4:0] LINK    = 5'd31;

  logic [31:0] pc, pc4, pc_next;
  logic [31:0] rf [1:31];

  wire [5:0]  op    = imem_rdata[31:26];
  wire [4:0]  rs    = imem_rdata[25:21];
  wire [4:0]  rt    = imem_rdata[20:16];
  wire [4:0]  rd    = imem_rdata[15:11];
  wire [5:0]  fn    = imem_rdata[5:0];
  wire [15:0] imm   = imem_rdata[15:0];
  wire [31:0] simm  = {{16{imm[15]}}, imm};
  wire [31:0] zimm  = {16'h0, imm};
  wire [31:0] a     = (rs == 5'd0) ? 32'h0 : rf[rs];
  wire [31:0] b     = (rt == 5'd0) ? 32'h0 : rf[rt];
  wire [31:0] br_t  = pc4 + {simm[29:0], 2'b00};
  wire [31:0] jmp_t = {pc4[31:28], imem_rdata[25:0], 2'b00};

  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;
  logic        st;

  assign pc4 = pc + 32'd4;

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = rt;
    wr_data = 32'h0;
    st      = 1'b0;
    pc_next = pc4;
    case (op)
      OP_REG: begin
        wr_idx = rd;
        case (fn)
          FN_ADD: begin wr_en = 1'b1; wr_data = a + b; end
          FN_SUB: begin wr_en = 1'b1; wr_data = a - b; end
          FN_SLT: begin wr_en = 1'b1; wr_data = {31'h0, $signed(a) < $signed(b)}; end
          FN_JR:  pc_next = a;
          default: ;
        endcase
      end
      OP_ADDI: begin wr_en = 1'b1; wr_data = a + simm; end
      OP_SLTI: begin wr_en = 1'b1; wr_data = {31'h0, $signed(a) < $signed(simm)}; end
      OP_ANDI: begin wr_en = 1'b1; wr_data = a & zimm; end
      OP_ORI:  begin wr_en = 1'b1; wr_data = a | zimm; end
      OP_LUI:  begin wr_en = 1'b1; wr_data = {imm, 16'h0}; end
      OP_LW:   begin wr_en = 1'b1; wr_data = dmem_rdata; end
      OP_SW:   st = 1'b1;
      OP_BEQ:  if (a == b) pc_next = br_t;
      OP_BNE:  if (a != b) pc_next = br_t;
      OP_J:    pc_next = jmp_t;
      OP_JAL:  begin wr_en = 1'b1; wr_idx = LINK; wr_data = pc4; pc_next = jmp_t; end
      default: ;
    endcase
  end

  wire commit = rst_n && wr_en && (wr_idx != 5'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= RESET_PC;
      for (int i = 1; i < 32; i++) rf[i] <= 32'h0;
    end else begin
      pc <= pc_next;
      if (commit) rf[wr_idx] <= wr_data;
    end
  end

  assign imem_addr   = pc;
  assign dmem_addr   = a + simm;
  assign dmem_wdata  = b;
  assign dmem_we     = rst_n && st;
  assign dbg_pc      = pc;
  assign dbg_wr_en   = commit;
  assign dbg_wr_idx  = wr_idx;
  assign dbg_wr_data = wr_data;
endmodule

module lsr_core_chk #(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] imem_rdata,
  input logic        dmem_we,
  input logic [31:0] dbg_pc,
  input logic        dbg_wr_en,
  input logic [4:0]  dbg_wr_idx,
  input logic [31:0] dbg_wr_data
);
  wire [5:0] op = imem_rdata[31:26];
  wire [5:0] fn = imem_rdata[5:0];
  wire known = (op == 6'd0) ? (fn == 6'd8 || fn == 6'd32 || fn == 6'd34 || fn == 6'd42)
             : (op == 6'd2 || op == 6'd3 || op == 6'd4 || op == 6'd5 || op == 6'd8 ||
                op == 6'd10 || op == 6'd12 || op == 6'd13 || op == 6'd15 ||
                op == 6'd35 || op == 6'd43);

  assert_reset_pc_R1: assert property (@(posedge clk) !rst_n |=> dbg_pc == RESET_PC);
  assert_pc_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n) dbg_pc[1:0] == 2'b00);
  assert_zero_reg_R6: assert property (@(posedge clk) disable iff (!rst_n) dbg_wr_en |-> dbg_wr_idx != 5'd0);
  assert_store_no_wb_R5: assert property (@(posedge clk) disable iff (!rst_n) dmem_we |-> !dbg_wr_en);
  assert_link_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 6'd3) |-> (dbg_wr_en && dbg_wr_idx == 5'd31 && dbg_wr_data == dbg_pc + 32'd4));
  assert_unknown_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !known |-> (!dbg_wr_en && !dmem_we));
  assert_unknown_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !known |=> dbg_pc == $past(dbg_pc) + 32'd4);
endmodule

bind lsr_core lsr_core_chk #(.RESET_PC(RESET_PC)) chk_i (
  .clk(clk), .rst_n(rst_n), .imem_rdata(imem_rdata), .dmem_we(dmem_we),
  .dbg_pc(dbg_pc), .dbg_wr_en(dbg_wr_en), .dbg_wr_idx(dbg_wr_idx), .dbg_wr_data(dbg_wr_data)
);

// File: tb/lsr_core_tb_top.sv
module lsr_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_rdata, dmem_wdata;
  logic        dmem_we;
  logic [31:0] dbg_pc;
  logic        dbg_wr_en;
  logic [4:0]  dbg_wr_idx;
  logic [31:0] dbg_wr_data;

  logic [31:0] imem [0:63];
  logic [31:0] dmem [0:63];

  int checks = 0;
  int errors = 0;
  logic [36:0] wq [$];
  logic [63:0] sq [$];

  always #2 clk = ~clk;

  lsr_core dut_i (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata), .dmem_wdata(dmem_wdata),
    .dmem_we(dmem_we), .dbg_pc(dbg_pc), .dbg_wr_en(dbg_wr_en),
    .dbg_wr_idx(dbg_wr_idx), .dbg_wr_data(dbg_wr_data)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] r_ins(int rs, int rt, int rd, int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction
  function automatic logic [31:0] i_ins(int op, int rs, int rt, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] j_ins(int op, int tgt);
    return {op[5:0], tgt[25:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push_w(int idx, logic [31:0] val);
    wq.push_back({idx[4:0], val});
  endtask
  task automatic push_s(logic [31:0] addr, logic [31:0] val);
    sq.push_back({addr, val});
  endtask

  // monitor: compares retired writes and stores with the scoreboard queues
  always @(negedge clk) begin
    if (rst_n && dbg_wr_en) begin
      if (wq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6/R10 unexpected write: actual r%0d=%h expected none", dbg_wr_idx, dbg_wr_data);
      end else begin
        logic [36:0] e;
        e = wq.pop_front();
        check("R2-R9 write index", {27'h0, dbg_wr_idx}, {27'h0, e[36:32]});
        check("R2-R9 write data", dbg_wr_data, e[31:0]);
      end
    end
    if (rst_n && dmem_we) begin
      if (sq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5/R10 unexpected store: actual %h expected none", dmem_addr);
      end else begin
        logic [63:0] s;
        s = sq.pop_front();
        check("R5 store address", dmem_addr, s[63:32]);
        check("R5 store data", dmem_wdata, s[31:0]);
      end
    end
  end

  initial begin
    int stable;
    for (int i = 0; i < 64; i++) begin imem[i] = 32'h0; dmem[i] = 32'h0; end
    imem[0]  = i_ins(15, 0, 1, 16'h1234);
    imem[1]  = i_ins(13, 1, 1, 16'h5678);
    imem[2]  = i_ins(8, 0, 2, 16'hFFFB);
    imem[3]  = i_ins(8, 0, 3, 7);
    imem[4]  = r_ins(2, 3, 4, 32);
    imem[5]  = r_ins(2, 3, 5, 34);
    imem[6]  = r_ins(2, 3, 6, 42);
    imem[7]  = r_ins(3, 2, 7, 42);
    imem[8]  = i_ins(10, 2, 8, 16'hFFFC);
    imem[9]  = i_ins(12, 1, 9, 16'hFF0F);
    imem[10] = i_ins(8, 0, 0, 9);
    imem[11] = r_ins(0, 3, 10, 32);
    imem[12] = i_ins(43, 0, 1, 16);
    imem[13] = i_ins(35, 0, 11, 16);
    imem[14] = 32'hFC00_0000;
    imem[15] = r_ins(1, 2, 20, 63);
    imem[16] = i_ins(4, 3, 10, 1);
    imem[17] = i_ins(8, 0, 12, 1);
    imem[18] = i_ins(5, 3, 10, 1);
    imem[19] = i_ins(8, 0, 13, 2);
    imem[20] = i_ins(8, 0, 16, 32);
    imem[21] = i_ins(43, 16, 5, 16'hFFF4);
    imem[22] = i_ins(35, 16, 17, 16'hFFF4);
    imem[23] = j_ins(3, 28);
    for (int i = 24; i < 28; i++) imem[i] = i_ins(8, 0, 14, 16'h55);
    imem[28] = i_ins(8, 0, 15, 132);
    imem[29] = r_ins(15, 0, 0, 8);
    for (int i = 30; i < 33; i++) imem[i] = i_ins(8, 0, 14, 16'h55);
    imem[33] = j_ins(2, 33);

    push_w(1, 32'h1234_0000);   // R4 lui
    push_w(1, 32'h1234_5678);   // R4 ori
    push_w(2, 32'hFFFF_FFFB);   // R4 addi sign-extended
    push_w(3, 32'd7);
    push_w(4, 32'd2);           // R2 add
    push_w(5, 32'hFFFF_FFF4);   // R2 sub
    push_w(6, 32'd1);           // R3 slt signed true
    push_w(7, 32'd0);           // R3 slt false
    push_w(8, 32'd1);           // R3 slti signed
    push_w(9, 32'h0000_5608);   // R4 andi zero-extended
    push_w(10, 32'd7);          // R6 r0 still zero
    push_w(11, 32'h1234_5678);  // R5 load
    push_w(13, 32'd2);          // R7 beq taken skips r12, bne not taken
    push_w(16, 32'd32);
    push_w(17, 32'hFFFF_FFF4);  // R5 negative displacement
    push_w(31, 32'd96);         // R8 link
    push_w(15, 32'd132);        // R8 jump target reached
    push_s(32'd16, 32'h1234_5678);
    push_s(32'd20, 32'hFFFF_FFF4);

    repeat (3) @(negedge clk);
    check("R1 reset PC", dbg_pc, 32'h0);
    check("R1 no write in reset", {31'h0, dbg_wr_en}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 PC steps by 4", dbg_pc, 32'd4);

    stable = 0;
    for (int cyc = 0; cyc < 2000 && stable < 6; cyc++) begin
      @(negedge clk);
      if (dbg_pc == 32'd132) stable++; else stable = 0;
    end
    if (stable < 6) begin
      checks++; errors++;
      $display("FAIL watchdog: actual pc %h expected 00000084", dbg_pc);
    end
    check("R9 jr landed and R8 j holds", dbg_pc, 32'd132);
    check("R7/R10 all writes seen", wq.size(), 0);
    check("R5 all stores seen", sq.size(), 0);
    check("R5 memory word 4", dmem[4], 32'h1234_5678);
    check("R5 memory word 5", dmem[5], 32'hFFFF_FFF4);
    check("R10 no stray store", dmem[0], 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule